// File: doc/BRIEF.md
# Interrupt Source Mode Gateway

This block is the per-source front end of a wired interrupt controller domain. It takes one raw interrupt line and turns its activity into a pending flag. A configuration word selects how the line is read: ignored, detached, rising edge, falling edge, high level or low level. The block also holds the source's enable flag. A register block drives single-cycle requests that clear pending, set enable or clear enable.

The gateway keeps the last input level it accepted and compares each new sample with it to find edges. A domain-wide enable bit and a per-source delegation bit can each freeze the input side. While the input side is frozen, neither pending nor the stored level moves. When enable and pending first become true together, the gateway raises a one-cycle notify strobe toward the hart-side logic. A reserved mode code does not set pending. An input change while such a code is selected raises a one-cycle error pulse instead.

Top module: `irq_src_gateway`

## Requirements
- R1: After reset, `pending_o`, `enabled_o`, `notify_o` and `mode_err_o` are 0 and the stored input level is 0. A line already high at reset release therefore counts as a rising edge.
- R2: The mode code sits in `cfg_word_i[2:0]`. With code 4 (rising edge), pending becomes 1 at the clock edge after the sampled input is 1 while the stored level is 0. A falling change does not set pending in this mode.
- R3: With code 5 (falling edge), pending becomes 1 when the sampled input is 0 while the stored level is 1. A rising change does not set pending in this mode.
- R4: With code 6 (high level), pending is set on every cycle the input is 1. With code 7 (low level), it is set on every cycle the input is 0. A later return of the input to its idle level leaves pending at 1.
- R5: With code 0 (inactive) or code 1 (detached), the input never sets pending. The stored level still follows the input, so a later switch to an edge mode sees no edge from a level that was already present.
- R6: Codes 2 and 3 are reserved. A change of the input while one of them is selected sets no pending and gives a one-cycle `mode_err_o` pulse. The stored level still follows the input.
- R7: While `cfg_word_i[10]` (delegated) is 1, the input is ignored: pending is not set and the stored level is frozen.
- R8: While `domain_en_i` is 0, the input is ignored in the same way: pending is not set and the stored level is frozen. `pend_clr_i` still clears pending in this state.
- R9: `en_set_i` and `en_clr_i` change `enabled_o` only while the mode code is non-zero. If both arrive in the same cycle, the clear wins.
- R10: `notify_o` is a one-cycle pulse. It appears in the same cycle in which enable and pending become 1 together, after either of them was 0. Pending without enable gives no pulse.
- R11: `pend_clr_i` takes priority over a pending set in the same cycle, in every mode. In a level mode, pending returns one cycle later if the level still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_level_i | input | 1 | Raw interrupt line |
| cfg_word_i | input | CFG_W | Source configuration: mode code in [2:0], delegation in [10] |
| domain_en_i | input | 1 | Domain-wide interrupt enable |
| pend_clr_i | input | 1 | Pending-clear request (one cycle) |
| en_set_i | input | 1 | Enable-set request (one cycle) |
| en_clr_i | input | 1 | Enable-clear request (one cycle) |
| pending_o | output | 1 | Pending flag |
| enabled_o | output | 1 | Enable flag |
| notify_o | output | 1 | Strobe when enabled and pending first coincide |
| mode_err_o | output | 1 | Pulse for an input change under a reserved mode code |

## Verification
The bench builds the gateway with `SYNC_STAGES = 0`, so an input sample acts at the very next clock edge. Each table row can then be checked exactly one cycle after it is driven, which brings cycle-exact checks of clear-versus-set priority and of the notify strobe within reach. Keeping the default field positions (mode in bits 2:0, delegation in bit 10) lets the frozen-stored-level cases be seen at the ports. The bench freezes the line high and then releases the freeze: if a rising edge still appears, the stored level did not move.

// File: rtl/irq_gw_pkg.sv
package irq_gw_pkg;

    localparam int unsigned MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        SM_OFF    = 3'd0,
        SM_DETACH = 3'd1,
        SM_RSV2   = 3'd2,
        SM_RSV3   = 3'd3,
        SM_RISE   = 3'd4,
        SM_FALL   = 3'd5,
        SM_HIGH   = 3'd6,
        SM_LOW    = 3'd7
    } src_mode_e;

    typedef struct packed {
        logic prev;    // last accepted input level
        logic pend;    // pending flag
        logic en;      // enable flag
        logic notify;  // enable-and-pending strobe
        logic err;     // reserved-mode input change
    } gw_state_t;

endpackage

// File: rtl/irq_gw_sampler.sv
module irq_gw_sampler #(
    parameter int unsigned STAGES = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic smp_o
);
    generate
        if (STAGES == 0) begin : g_direct
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst_n;
            assign smp_o = raw_i;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            logic [STAGES-1:0] chain_d;
            if (STAGES == 1) begin : g_one
                assign chain_d = raw_i;
            end else begin : g_many
                assign chain_d = {chain_q[STAGES-2:0], raw_i};
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end
            assign smp_o = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/irq_gw_cfg_decode.sv
module irq_gw_cfg_decode
    import irq_gw_pkg::*;
#(
    parameter int unsigned CFG_W     = 32,
    parameter int unsigned MODE_LSB  = 0,
    parameter int unsigned DELEG_BIT = 10
) (
    input  logic [CFG_W-1:0] cfg_i,
    output src_mode_e        mode_o,
    output logic             deleg_o,
    output logic             active_o,
    output logic             reserved_o
);
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^cfg_i;

    always_comb begin
        mode_o     = src_mode_e'(cfg_i[MODE_LSB +: MODE_W]);
        deleg_o    = cfg_i[DELEG_BIT];
        active_o   = (mode_o != SM_OFF);
        reserved_o = (mode_o == SM_RSV2) || (mode_o == SM_RSV3);
    end
endmodule

// File: rtl/irq_gw_trigger.sv
module irq_gw_trigger
    import irq_gw_pkg::*;
(
    input  src_mode_e mode_i,
    input  logic      smp_i,
    input  logic      prev_i,
    output logic      set_o,
    output logic      change_o
);
    always_comb begin
        change_o = smp_i ^ prev_i;
        unique case (mode_i)
            SM_RISE: set_o = smp_i & ~prev_i;
            SM_FALL: set_o = ~smp_i & prev_i;
            SM_HIGH: set_o = smp_i;
            SM_LOW:  set_o = ~smp_i;
            default: set_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_src_gateway.sv
module irq_src_gateway
    import irq_gw_pkg::*;
#(
    parameter int unsigned CFG_W       = 32,
    parameter int unsigned MODE_LSB    = 0,
    parameter int unsigned DELEG_BIT   = 10,
    parameter int unsigned SYNC_STAGES = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_level_i,
    input  logic [CFG_W-1:0] cfg_word_i,
    input  logic             domain_en_i,
    input  logic             pend_clr_i,
    input  logic             en_set_i,
    input  logic             en_clr_i,
    output logic             pending_o,
    output logic             enabled_o,
    output logic             notify_o,
    output logic             mode_err_o
);
    gw_state_t st_d, st_q;

    logic      smp;
    src_mode_e mode;
    logic      deleg, active, reserved;
    logic      set_req, changed;
    logic      accept;

    irq_gw_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (src_level_i),
        .smp_o (smp)
    );

    irq_gw_cfg_decode #(
        .CFG_W     (CFG_W),
        .MODE_LSB  (MODE_LSB),
        .DELEG_BIT (DELEG_BIT)
    ) u_decode (
        .cfg_i      (cfg_word_i),
        .mode_o     (mode),
        .deleg_o    (deleg),
        .active_o   (active),
        .reserved_o (reserved)
    );

    irq_gw_trigger u_trigger (
        .mode_i   (mode),
        .smp_i    (smp),
        .prev_i   (st_q.prev),
        .set_o    (set_req),
        .change_o (changed)
    );

    always_comb begin
        st_d   = st_q;
        accept = domain_en_i && !deleg;

        // stored level follows the input only when the input side is open
        if (accept) st_d.prev = smp;

        // clear always wins in its own cycle; a held level re-sets next cycle
        if (pend_clr_i)            st_d.pend = 1'b0;
        else if (accept && set_req) st_d.pend = 1'b1;

        if (active) begin
            if (en_clr_i)      st_d.en = 1'b0;
            else if (en_set_i) st_d.en = 1'b1;
        end

        st_d.err    = accept && reserved && changed;
        st_d.notify = st_d.en && st_d.pend && !(st_q.en && st_q.pend);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending_o  = st_q.pend;
    assign enabled_o  = st_q.en;
    assign notify_o   = st_q.notify;
    assign mode_err_o = st_q.err;
endmodule

// File: rtl/irq_src_gateway_chk.sv
module irq_src_gateway_chk #(
    parameter int unsigned CFG_W       = 32,
    parameter int unsigned MODE_LSB    = 0,
    parameter int unsigned DELEG_BIT   = 10,
    parameter int unsigned SYNC_STAGES = 0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             src_level_i,
    input logic [CFG_W-1:0] cfg_word_i,
    input logic             domain_en_i,
    input logic             pend_clr_i,
    input logic             en_set_i,
    input logic             en_clr_i,
    input logic             pending_o,
    input logic             enabled_o,
    input logic             notify_o,
    input logic             mode_err_o
);
    logic [2:0] c_mode;
    logic       c_deleg;
    logic       c_open;
    assign c_mode  = cfg_word_i[MODE_LSB +: 3];
    assign c_deleg = cfg_word_i[DELEG_BIT];
    assign c_open  = domain_en_i && !c_deleg;

    // R4: high level with nothing blocking sets pending at the next edge
    p_level_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((SYNC_STAGES == 0) && c_open && (c_mode == 3'd6) && src_level_i && !pend_clr_i)
        |=> pending_o);

    // R6: an error pulse never comes with a new pending
    p_reserved_no_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o |-> !$rose(pending_o));

    // R7: delegated source cannot raise pending
    p_deleg_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        c_deleg |=> !$rose(pending_o));

    // R8: domain disabled cannot raise pending
    p_domain_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !domain_en_i |=> !$rose(pending_o));

    // R9: inactive mode holds the enable flag
    p_inactive_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (c_mode == 3'd0) |=> $stable(enabled_o));

    // R10: notify only with both flags up, and lasts one cycle
    p_notify_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        notify_o |-> (pending_o && enabled_o));
    p_notify_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        notify_o |=> !notify_o);

    // R11: clear request always drops pending at the next edge
    p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pend_clr_i |=> !pending_o);
endmodule

bind irq_src_gateway irq_src_gateway_chk #(
    .CFG_W       (CFG_W),
    .MODE_LSB    (MODE_LSB),
    .DELEG_BIT   (DELEG_BIT),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_level_i (src_level_i),
    .cfg_word_i  (cfg_word_i),
    .domain_en_i (domain_en_i),
    .pend_clr_i  (pend_clr_i),
    .en_set_i    (en_set_i),
    .en_clr_i    (en_clr_i),
    .pending_o   (pending_o),
    .enabled_o   (enabled_o),
    .notify_o    (notify_o),
    .mode_err_o  (mode_err_o)
);

// File: tb/irq_src_gateway_bench.sv
module irq_src_gateway_bench;
    localparam int unsigned CFG_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             src_level_i = 1'b0;
    logic [CFG_W-1:0] cfg_word_i = '0;
    logic             domain_en_i = 1'b0;
    logic             pend_clr_i = 1'b0;
    logic             en_set_i = 1'b0;
    logic             en_clr_i = 1'b0;
    logic             pending_o, enabled_o, notify_o, mode_err_o;

    int n_checks = 0;
    int n_bad    = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    irq_src_gateway #(
        .CFG_W       (CFG_W),
        .MODE_LSB    (0),
        .DELEG_BIT   (10),
        .SYNC_STAGES (0)
    ) u_irq_src_gateway (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_level_i (src_level_i),
        .cfg_word_i  (cfg_word_i),
        .domain_en_i (domain_en_i),
        .pend_clr_i  (pend_clr_i),
        .en_set_i    (en_set_i),
        .en_clr_i    (en_clr_i),
        .pending_o   (pending_o),
        .enabled_o   (enabled_o),
        .notify_o    (notify_o),
        .mode_err_o  (mode_err_o)
    );

    typedef struct packed {
        logic [2:0] mode;
        logic       dl;   // delegation bit
        logic       de;   // domain enable
        logic       lv;   // input level
        logic       cl;   // pending clear
        logic       es;   // enable set
        logic       ec;   // enable clear
        logic       xp;   // expected pending
        logic       xe;   // expected enable
        logic       xn;   // expected notify
        logic       xr;   // expected error
        logic [3:0] req;
    } vec_t;

    localparam int NV = 41;
    localparam vec_t VECS [NV] = '{
        '{3'd4,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd9 },  // R9 set in rise mode
        '{3'd4,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0, 4'd2 },  // R2 rise
        '{3'd4,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd10},  // R10 one cycle
        '{3'd4,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd11},  // R11 clear
        '{3'd4,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd2 },  // R2 fall ignored
        '{3'd5,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd3 },
        '{3'd5,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd3 },  // R3 rise ignored
        '{3'd5,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0, 4'd3 },  // R3 fall
        '{3'd5,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd11},
        '{3'd6,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0, 4'd4 },  // R4 high
        '{3'd6,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd11},  // R11 clear beats level
        '{3'd6,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0, 4'd11},  // R11 re-set
        '{3'd6,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b0,1'b0, 4'd4 },  // R4 persists
        '{3'd6,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd11},
        '{3'd7,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0, 4'd4 },  // R4 low
        '{3'd7,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd4 },
        '{3'd7,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd9 },  // R9 clear
        '{3'd7,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0, 4'd10},  // R10 no enable
        '{3'd7,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b1,1'b1,1'b1,1'b0, 4'd10},  // R10 via enable
        '{3'd0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd5 },
        '{3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 1'b0,1'b1,1'b0,1'b0, 4'd9 },  // R9 inactive ignore
        '{3'd0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd5 },  // R5 inactive
        '{3'd4,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd5 },  // R5 level tracked
        '{3'd1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd5 },  // R5 detached
        '{3'd4,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0, 4'd5 },
        '{3'd4,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd11},
        '{3'd2,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd6 },  // R6 code 2
        '{3'd3,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd6 },  // R6 no change
        '{3'd3,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd6 },  // R6 code 3
        '{3'd4,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd6 },  // R6 level tracked
        '{3'd4,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd7 },
        '{3'd4,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd7 },  // R7 ignored
        '{3'd4,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0, 4'd7 },  // R7 level frozen
        '{3'd4,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd11},
        '{3'd4,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd8 },
        '{3'd4,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd8 },  // R8 ignored
        '{3'd4,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b0, 4'd8 },  // R8 level frozen
        '{3'd6,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd8 },  // R8 clear works
        '{3'd6,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd8 },  // R8 level ignored
        '{3'd6,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0, 4'd7 },  // R7 level ignored
        '{3'd4,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd9 }   // R9 clear wins
    };

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {pend,en,notify,err} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 in reset", {pending_o, enabled_o, notify_o, mode_err_o}, 4'b0000);
        rst_n = 1'b1;
        domain_en_i = 1'b1;
        @(negedge clk);
        check("R1 after release", {pending_o, enabled_o, notify_o, mode_err_o}, 4'b0000);

        for (int i = 0; i < NV; i++) begin
            cfg_word_i       = '0;
            cfg_word_i[2:0]  = VECS[i].mode;
            cfg_word_i[10]   = VECS[i].dl;
            domain_en_i      = VECS[i].de;
            src_level_i      = VECS[i].lv;
            pend_clr_i       = VECS[i].cl;
            en_set_i         = VECS[i].es;
            en_clr_i         = VECS[i].ec;
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d row %0d", VECS[i].req, i),
                  {pending_o, enabled_o, notify_o, mode_err_o},
                  {VECS[i].xp, VECS[i].xe, VECS[i].xn, VECS[i].xr});
        end

        // R1: reset mid-run clears flags and the stored level
        pend_clr_i = 1'b0; en_clr_i = 1'b0; en_set_i = 1'b1;
        cfg_word_i = '0; cfg_word_i[2:0] = 3'd6; domain_en_i = 1'b1; src_level_i = 1'b1;
        @(posedge clk); @(negedge clk);
        en_set_i = 1'b0;
        check("R1 pre-reset set", {pending_o, enabled_o, notify_o, mode_err_o}, 4'b1110);
        cfg_word_i[2:0] = 3'd4;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", {pending_o, enabled_o, notify_o, mode_err_o}, 4'b0000);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 stored level cleared", {pending_o, enabled_o, notify_o, mode_err_o}, 4'b1000);

        done = 1'b1;
        finish_run();
    end
endmodule